// File: doc/BRIEF.md
# Masked Vector Pack/Unpack Engine

This engine rearranges the elements of a vector register under a per-element mask bit. In pack mode, it gathers the selected source elements into a dense run that starts at the destination's lowest slot, keeps their original order, and reports how many it moved. In unpack mode, it does the reverse. It takes source elements one by one from slot 0 upward and places each into the next selected destination slot. Slots that are not selected keep the value they held before, so a dense result can be merged back into a sparse vector.

A requester presents the source vector, the mask, the prior destination contents, an active length and the mode all at once, then pulses a start input. The engine moves one element per clock. It raises a one-cycle completion pulse and then holds the final vector and count on its outputs until the next job. Only elements below the active length take part. An active length larger than the vector size is treated as the full vector size.

Top module: `vmx_engine`

## Requirements
- R1: In pack mode (`op_i` = 0) the selected source elements appear in result slots 0, 1, 2, … in increasing source index order. Element i occupies bits [i*EW +: EW] of every vector port, and mask bit i belongs to element i.
- R2: `count_o` equals the number of selected elements. This is the population count of the mask after length trimming, and it holds in both modes.
- R3: In pack mode, result slots at or above `count_o` keep the value given on `dst_i`.
- R4: In unpack mode (`op_i` = 1) the k-th source element (k counted from 0) is written to the slot of the k-th selected mask bit, counted from bit 0 upward.
- R5: In unpack mode, result slots whose mask bit is 0 keep the value given on `dst_i`.
- R6: Mask bits at index `vlen_i` or higher count as 0. A `vlen_i` above ELEMS behaves as ELEMS.
- R7: The start is accepted on clock edge e0. `done_o` is then high for exactly one cycle, after edge e0+L, where L is the effective length (0 to ELEMS). `busy_o` is high only while elements are being processed.
- R8: A start pulse that arrives while `busy_o` is high is ignored. Its mode, length and data do not affect the job in flight, and no second job follows.
- R9: An all-zero effective mask gives `count_o` = 0 and a result equal to `dst_i` in either mode.
- R10: After synchronous reset `busy_o`, `done_o`, `count_o` and `res_o` are all 0.
- R11: A start presented in the same cycle that `done_o` is high is accepted as a new job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Job request, sampled when not busy |
| op_i | input | 1 | 0 = pack, 1 = unpack |
| vlen_i | input | $clog2(ELEMS+1) | Active vector length |
| mask_i | input | ELEMS | Per-element select bits |
| src_i | input | ELEMS*EW | Source vector |
| dst_i | input | ELEMS*EW | Prior destination contents |
| busy_o | output | 1 | Elements are being processed |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | ELEMS*EW | Resulting vector, held after completion |
| count_o | output | $clog2(ELEMS+1) | Number of selected elements |

## Verification
Both modes are tried with a scattered mask, a full mask and an empty mask. The scattered mask separates a correct order-preserving walk from one that fills slots in the wrong direction. The full mask and the empty mask isolate the pointer advance and the keep-old-value path. Jobs with a partial length whose mask has bits set above the length, along with a zero length and an oversized length, show whether trimming and clamping are done before counting. Back-to-back jobs and a start raised mid-job tell correct acceptance apart from acceptance that is too early or too late.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vmx_state_e;

    typedef enum logic {
        OP_PACK   = 1'b0,
        OP_UNPACK = 1'b1
    } vmx_op_e;

    typedef struct packed {
        vmx_op_e op;
        logic    load;
        logic    step;
        logic    fin;
    } vmx_ctl_t;

    function automatic logic [7:0] ones64(input logic [63:0] v);
        logic [7:0] n;
        n = '0;
        for (int i = 0; i < 64; i++) begin
            n = n + {7'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/vmx_trim.sv
module vmx_trim #(
    parameter int ELEMS = 8,
    localparam int LW = $clog2(ELEMS + 1)
) (
    input  logic [LW-1:0]    vlen_i,
    input  logic [ELEMS-1:0] mask_i,
    output logic [LW-1:0]    eff_len_o,
    output logic [ELEMS-1:0] mask_o
);

    assign eff_len_o = (vlen_i > LW'(ELEMS)) ? LW'(ELEMS) : vlen_i;

    for (genvar g = 0; g < ELEMS; g++) begin : g_bit
        assign mask_o[g] = mask_i[g] & (LW'(g) < eff_len_o);
    end

    always_comb begin
        assert (eff_len_o <= LW'(ELEMS))
            else $error("AST_LEN_CLAMPED"); // R6
    end

endmodule

// File: rtl/vmx_ctrl.sv
module vmx_ctrl
    import vmx_pkg::*;
#(
    parameter int ELEMS = 8,
    localparam int LW = $clog2(ELEMS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          op_i,
    input  logic [LW-1:0] eff_len_i,
    output vmx_ctl_t      ctl_o,
    output logic [LW-1:0] idx_o,
    output logic          busy_o,
    output logic          done_o
);

    vmx_state_e    state_q;
    logic [LW-1:0] idx_q;
    logic [LW-1:0] len_q;
    vmx_op_e       op_q;
    logic          accept;
    logic          last;

    assign accept = start_i && (state_q != ST_RUN);
    assign last   = (idx_q == len_q - LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            op_q    <= OP_PACK;
        end else if (accept) begin
            state_q <= (eff_len_i == '0) ? ST_FIN : ST_RUN;
            idx_q   <= '0;
            len_q   <= eff_len_i;
            op_q    <= vmx_op_e'(op_i);
        end else begin
            case (state_q)
                ST_RUN: begin
                    idx_q <= idx_q + LW'(1);
                    if (last) state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.op   = accept ? vmx_op_e'(op_i) : op_q;
        ctl_o.load = accept;
        ctl_o.step = (state_q == ST_RUN);
        ctl_o.fin  = (state_q == ST_FIN);
    end

    assign idx_o  = idx_q;
    assign busy_o = (state_q == ST_RUN);
    assign done_o = (state_q == ST_FIN);

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (idx_q < len_q)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !done_o); // R7
    AST_BUSY_KEEPS_LEN: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last) |=> (busy_o && $stable(len_q))); // R8

endmodule

// File: rtl/vmx_dp.sv
module vmx_dp
    import vmx_pkg::*;
#(
    parameter int ELEMS = 8,
    parameter int EW    = 16,
    localparam int LW = $clog2(ELEMS + 1),
    localparam int IW = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  vmx_ctl_t            ctl_i,
    input  logic [LW-1:0]       idx_i,
    input  logic [ELEMS-1:0]    mask_i,
    input  logic [ELEMS*EW-1:0] src_i,
    input  logic [ELEMS*EW-1:0] dst_i,
    output logic [ELEMS*EW-1:0] res_o,
    output logic [LW-1:0]       count_o
);

    logic [EW-1:0]    src_q [ELEMS];
    logic [EW-1:0]    dst_q [ELEMS];
    logic [ELEMS-1:0] mask_q;
    logic [LW-1:0]    k_q;
    logic [IW-1:0]    i_sel;
    logic [IW-1:0]    k_sel;
    logic             hit;

    assign i_sel = idx_i[IW-1:0];
    assign k_sel = k_q[IW-1:0];
    assign hit   = ctl_i.step && mask_q[i_sel];

    for (genvar g = 0; g < ELEMS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[g] <= '0;
                dst_q[g] <= '0;
            end else if (ctl_i.load) begin
                src_q[g] <= src_i[g*EW +: EW];
                dst_q[g] <= dst_i[g*EW +: EW];
            end else if (hit) begin
                if (ctl_i.op == OP_PACK && k_sel == IW'(g)) begin
                    dst_q[g] <= src_q[i_sel];
                end else if (ctl_i.op == OP_UNPACK && i_sel == IW'(g)) begin
                    dst_q[g] <= src_q[k_sel];
                end
            end
        end
        assign res_o[g*EW +: EW] = dst_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            k_q    <= '0;
        end else if (ctl_i.load) begin
            mask_q <= mask_i;
            k_q    <= '0;
        end else if (hit) begin
            k_q <= k_q + LW'(1);
        end
    end

    assign count_o = k_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        k_q <= LW'(ELEMS)); // R2
    AST_COUNT_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
        ctl_i.fin |-> (64'(count_o) == 64'(ones64(64'(mask_q))))); // R2
    AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.step && !mask_q[i_sel]) |=> $stable(res_o)); // R5
    AST_PACK_NO_OVERTAKE: assert property (@(posedge clk) disable iff (rst)
        ctl_i.step |-> (k_q <= idx_i)); // R1

endmodule

// File: rtl/vmx_engine.sv
module vmx_engine
    import vmx_pkg::*;
#(
    parameter int ELEMS = 8,
    parameter int EW    = 16,
    localparam int LW = $clog2(ELEMS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                op_i,
    input  logic [LW-1:0]       vlen_i,
    input  logic [ELEMS-1:0]    mask_i,
    input  logic [ELEMS*EW-1:0] src_i,
    input  logic [ELEMS*EW-1:0] dst_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [ELEMS*EW-1:0] res_o,
    output logic [LW-1:0]       count_o
);

    logic [LW-1:0]    eff_len;
    logic [ELEMS-1:0] mask_trim;
    logic [LW-1:0]    idx;
    vmx_ctl_t         ctl;

    vmx_trim #(.ELEMS(ELEMS)) i_trim (
        .vlen_i    (vlen_i),
        .mask_i    (mask_i),
        .eff_len_o (eff_len),
        .mask_o    (mask_trim)
    );

    vmx_ctrl #(.ELEMS(ELEMS)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .op_i      (op_i),
        .eff_len_i (eff_len),
        .ctl_o     (ctl),
        .idx_o     (idx),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    vmx_dp #(.ELEMS(ELEMS), .EW(EW)) i_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .idx_i   (idx),
        .mask_i  (mask_trim),
        .src_i   (src_i),
        .dst_i   (dst_i),
        .res_o   (res_o),
        .count_o (count_o)
    );

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o)); // R7

endmodule

// File: tb/test_vmx_engine.sv
module test_vmx_engine;

    localparam int ELEMS = 8;
    localparam int EW    = 16;
    localparam int LW    = $clog2(ELEMS + 1);
    localparam int VW    = ELEMS * EW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic [LW-1:0] vlen_i = '0;
    logic [7:0]    mask_i = '0;
    logic [VW-1:0] src_i = '0;
    logic [VW-1:0] dst_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [VW-1:0] res_o;
    logic [LW-1:0] count_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit summary_done = 0;

    always #10 clk = ~clk;

    vmx_engine #(.ELEMS(ELEMS), .EW(EW)) i_vmx_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .vlen_i(vlen_i),
        .mask_i(mask_i), .src_i(src_i), .dst_i(dst_i), .busy_o(busy_o),
        .done_o(done_o), .res_o(res_o), .count_o(count_o)
    );

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] model(input bit op, input int vl, input logic [7:0] m,
                                            input logic [VW-1:0] s, input logic [VW-1:0] d,
                                            output int cnt);
        logic [VW-1:0] r;
        int eff;
        eff = (vl > ELEMS) ? ELEMS : vl;
        r = d;
        cnt = 0;
        for (int i = 0; i < eff; i++) begin
            if (m[i]) begin
                if (!op) r[cnt*EW +: EW] = s[i*EW +: EW];
                else     r[i*EW +: EW]   = s[cnt*EW +: EW];
                cnt++;
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] fill(input logic [7:0] base);
        logic [VW-1:0] v;
        for (int i = 0; i < ELEMS; i++) v[i*EW +: EW] = {base, 8'(i)};
        return v;
    endfunction

    // Drives one job, waits for done, checks latency, result, count and the pulse end.
    task automatic run_job(input string req, input bit op, input int vl, input logic [7:0] m,
                           input logic [VW-1:0] s, input logic [VW-1:0] d);
        logic [VW-1:0] exp_r;
        int exp_c, eff, cyc;
        exp_r = model(op, vl, m, s, d, exp_c);
        eff = (vl > ELEMS) ? ELEMS : vl;
        op_i = op; vlen_i = LW'(vl); mask_i = m; src_i = s; dst_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check({req, " R7 latency"}, VW'(cyc), VW'(eff + 1));
        check({req, " result"}, res_o, exp_r);
        check({req, " R2 count"}, VW'(count_o), VW'(exp_c));
        @(negedge clk);
        check({req, " R7 pulse end"}, VW'({done_o, busy_o}), '0);
    endtask

    task automatic t_reset;
        check("R10 reset", VW'({busy_o, done_o, count_o}), '0);
        check("R10 reset res", res_o, '0);
    endtask

    task automatic t_pack_scattered;   // R1 R3
        run_job("R1 R3 pack scattered", 1'b0, 8, 8'b1011_0010, fill(8'hA0), fill(8'h50));
    endtask

    task automatic t_unpack_scattered; // R4 R5
        run_job("R4 R5 unpack scattered", 1'b1, 8, 8'b1011_0010, fill(8'hB0), fill(8'h60));
    endtask

    task automatic t_full_masks;       // R1 R4
        run_job("R1 pack full", 1'b0, 8, 8'hFF, fill(8'hC0), fill(8'h11));
        run_job("R4 unpack full", 1'b1, 8, 8'hFF, fill(8'hC1), fill(8'h12));
    endtask

    task automatic t_empty_masks;      // R9
        run_job("R9 pack empty", 1'b0, 8, 8'h00, fill(8'hD0), fill(8'h21));
        run_job("R9 unpack empty", 1'b1, 8, 8'h00, fill(8'hD1), fill(8'h22));
    endtask

    task automatic t_lengths;          // R6
        run_job("R6 pack trimmed", 1'b0, 5, 8'b1110_0101, fill(8'hE0), fill(8'h31));
        run_job("R6 unpack trimmed", 1'b1, 3, 8'b1111_0110, fill(8'hE1), fill(8'h32));
        run_job("R6 R9 zero length", 1'b0, 0, 8'hFF, fill(8'hE2), fill(8'h33));
        run_job("R6 clamp length", 1'b1, 15, 8'b0101_0101, fill(8'hE3), fill(8'h34));
    endtask

    task automatic t_start_while_busy; // R8
        logic [VW-1:0] exp_r;
        int exp_c, cyc;
        exp_r = model(1'b0, 6, 8'b0011_1010, fill(8'hF0), fill(8'h41), exp_c);
        op_i = 1'b0; vlen_i = LW'(6); mask_i = 8'b0011_1010;
        src_i = fill(8'hF0); dst_i = fill(8'h41); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        op_i = 1'b1; vlen_i = LW'(8); mask_i = 8'hFF; src_i = fill(8'h99); dst_i = fill(8'h77);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 3;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check("R8 latency unchanged", VW'(cyc), VW'(7));
        check("R8 result of first job", res_o, exp_r);
        check("R8 count of first job", VW'(count_o), VW'(exp_c));
        @(negedge clk);
        check("R8 no second job", VW'({done_o, busy_o}), '0);
    endtask

    task automatic t_back_to_back;     // R11
        logic [VW-1:0] exp_r;
        int exp_c, cyc;
        exp_r = model(1'b1, 4, 8'b0000_1001, fill(8'h81), fill(8'h82), exp_c);
        op_i = 1'b0; vlen_i = LW'(2); mask_i = 8'b10; src_i = fill(8'h80); dst_i = fill(8'h40);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        op_i = 1'b1; vlen_i = LW'(4); mask_i = 8'b0000_1001;
        src_i = fill(8'h81); dst_i = fill(8'h82); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R11 accepted on done cycle", VW'(busy_o), VW'(1));
        cyc = 1;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check("R11 latency", VW'(cyc), VW'(5));
        check("R11 result", res_o, exp_r);
        check("R11 count", VW'(count_o), VW'(exp_c));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pack_scattered();
        t_unpack_scattered();
        t_full_masks();
        t_empty_masks();
        t_lengths();
        t_start_while_busy();
        t_back_to_back();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !summary_done) begin
            summary_done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule